// File: doc/BRIEF.md
# HDM Decoder Register Bank

This block stores the configuration registers for a small set of host-managed memory address decoders: one read-only capability word, one global control word and seven words per decoder (base, size and target list, each split into low and high halves, plus a control word). Software reaches it through a simple 32-bit register port. A request carries a byte offset, a write flag, write data and a flag that marks it as a 64-bit access. Reads return one cycle later on a response strobe.

Every write is merged through a fixed per-register mask, so read-only bits keep their value. A write to a decoder's control word is treated as a request. If the request bit is set, the block reports the decoder as committed with no error. If the request bit is clear, it reports the decoder as not committed, also with no error. The bank does no address translation itself. Downstream logic reads the stored fields.

Register map (byte offsets): 0x00 capability, 0x04 global control, 0x08 and 0x0C unmapped. Decoder n occupies 0x10 + 0x20·n. Within that slot the words are: +0x00 base low, +0x04 base high, +0x08 size low, +0x0C size high, +0x10 control, +0x14 target list low, +0x18 target list high, and +0x1C is unmapped.

Top module: `hdm_reg_bank`

## Requirements
- R1: Only 32-bit requests (req_wide low) change state. A write with req_wide high leaves every register unchanged. A read with req_wide high returns 0.
- R2: A write stores (wdata & mask) | (current & ~mask). Base-low and size-low have mask 0xF000_0000. Base-high, size-high and target-high have mask 0xFFFF_FFFF. All decoder words reset to 0.
- R3: The control word has mask 0x0000_13FF. Bit 9 is the commit request, bit 10 is the committed flag and bit 11 is the error flag.
- R4: A control write whose bit 9 is 1 stores the merged value with bit 10 forced to 1 and bit 11 forced to 0.
- R5: A control write whose bit 9 is 0 stores the merged value with bits 10 and 11 forced to 0.
- R6: Only bits [1:0] of global control are writable, and the word resets to 0. Bit 0 is the global decoder enable.
- R7: The capability word is read-only. Its fields are: decoder-count code in [3:0] (code 2 means 4 decoders), target count in [7:4] (1), 256-byte interleave support in bit 8 (1), 4-KiB interleave support in bit 9 (1), and poison-on-error support in bit 10 (0). With the default parameters it reads 0x0000_0312.
- R8: The target-low mask is 0xF000_0000 when DEV_IS_ENDPOINT is 1 (the default) and 0xFFFF_FFFF when it is 0.
- R9: Writes to unmapped or non-word-aligned offsets are dropped. Reads of such offsets return 0.
- R10: rsp_valid pulses exactly one cycle after each accepted read and never after a write. A synchronous reset returns every register to its default value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | Marks a 64-bit access (no effect on state) |
| req_addr | input | ADDR_W (8) | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after read |
| rsp_rdata | output | 32 | Read data |

## Verification
Stored state is visible only through reads. A corrupted mask, a missed force of the committed or error bit, or a write that lands in the wrong decoder slot therefore shows up on rsp_rdata at the first read of the affected word, one cycle after that read is issued. A broken decode of unmapped offsets, or of the 64-bit flag, also appears as non-zero read data or as a changed neighbour word on the next read. A timing fault appears at once as a response strobe with no matching read in flight.

// File: rtl/hdm_regs_pkg.sv
package hdm_regs_pkg;

    typedef enum logic [1:0] {
        TGT_CAP   = 2'd0,
        TGT_GCTRL = 2'd1,
        TGT_DEC   = 2'd2,
        TGT_NONE  = 2'd3
    } tgt_e;

    // Order matches word position inside a decoder slot.
    typedef enum logic [2:0] {
        FLD_BASE_LO = 3'd0,
        FLD_BASE_HI = 3'd1,
        FLD_SIZE_LO = 3'd2,
        FLD_SIZE_HI = 3'd3,
        FLD_CTRL    = 3'd4,
        FLD_TGT_LO  = 3'd5,
        FLD_TGT_HI  = 3'd6,
        FLD_NONE    = 3'd7
    } fld_e;

    localparam int          NUM_FLD       = 7;
    localparam int          SLOT_BASE     = 16;
    localparam int          SLOT_SHIFT    = 5;
    localparam logic [31:0] MASK_LOW      = 32'hF000_0000;
    localparam logic [31:0] MASK_FULL     = 32'hFFFF_FFFF;
    localparam logic [31:0] MASK_CTRL     = 32'h0000_13FF;
    localparam logic [31:0] MASK_GCTRL    = 32'h0000_0003;
    localparam int          CTRL_REQ_BIT  = 9;
    localparam int          CTRL_DONE_BIT = 10;
    localparam int          CTRL_ERR_BIT  = 11;

    function automatic logic [3:0] count_code(input int n);
        case (n)
            1:  return 4'h0;
            2:  return 4'h1;
            4:  return 4'h2;
            6:  return 4'h3;
            8:  return 4'h4;
            10: return 4'h5;
            12: return 4'h6;
            14: return 4'h7;
            16: return 4'h8;
            20: return 4'h9;
            24: return 4'hA;
            28: return 4'hB;
            32: return 4'hC;
            default: return 4'h0;
        endcase
    endfunction

    function automatic logic [31:0] cap_word(input int n);
        logic [31:0] w;
        w        = '0;
        w[3:0]   = count_code(n);
        w[7:4]   = 4'd1;
        w[8]     = 1'b1;
        w[9]     = 1'b1;
        w[10]    = 1'b0;
        return w;
    endfunction

    function automatic logic [31:0] fld_mask(input int f, input logic [31:0] tgt_lo_mask);
        case (f)
            0, 2:    return MASK_LOW;
            4:       return MASK_CTRL;
            5:       return tgt_lo_mask;
            default: return MASK_FULL;
        endcase
    endfunction

endpackage

// File: rtl/hdm_addr_decode.sv
module hdm_addr_decode
    import hdm_regs_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_DEC = 4,
    parameter int DEC_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_e              kind,
    output fld_e              fld,
    output logic [DEC_W-1:0]  idx
);
    logic [ADDR_W-1:0] rel;
    logic [31:0]       slot_n;

    always_comb begin
        kind   = TGT_NONE;
        fld    = FLD_NONE;
        idx    = '0;
        rel    = addr - ADDR_W'(SLOT_BASE);
        slot_n = 32'(rel >> SLOT_SHIFT);
        if (addr[1:0] == 2'b00) begin
            if (addr < ADDR_W'(SLOT_BASE)) begin
                if (addr[3:2] == 2'd0)      kind = TGT_CAP;
                else if (addr[3:2] == 2'd1) kind = TGT_GCTRL;
            end else if (slot_n < 32'(NUM_DEC) && rel[4:2] != 3'd7) begin
                kind = TGT_DEC;
                fld  = fld_e'(rel[4:2]);
                idx  = DEC_W'(slot_n);
            end
        end
    end
endmodule

// File: rtl/hdm_dec_slot.sv
module hdm_dec_slot
    import hdm_regs_pkg::*;
#(
    parameter logic [31:0] TGT_LO_MASK = 32'hF000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  fld_e        fld,
    input  logic [31:0] wdata,
    output logic [31:0] rd_data
);
    logic [31:0] field_q [NUM_FLD];

    for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
        localparam logic [31:0] MASK = fld_mask(f, TGT_LO_MASK);
        logic [31:0] q;
        logic [31:0] merged;

        always_comb begin
            merged = (wdata & MASK) | (q & ~MASK);
            if (f == int'(FLD_CTRL)) begin
                merged[CTRL_DONE_BIT] = merged[CTRL_REQ_BIT];
                merged[CTRL_ERR_BIT]  = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst)                             q <= '0;
            else if (wr_en && fld == fld_e'(f))  q <= merged;
        end

        assign field_q[f] = q;
    end

    assign rd_data = (fld == FLD_NONE) ? 32'h0 : field_q[fld];

    AST_COMMIT_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fld == FLD_CTRL && wdata[CTRL_REQ_BIT])
        |=> (field_q[FLD_CTRL][CTRL_DONE_BIT] && !field_q[FLD_CTRL][CTRL_ERR_BIT])); // R4
    AST_UNCOMMIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fld == FLD_CTRL && !wdata[CTRL_REQ_BIT])
        |=> (!field_q[FLD_CTRL][CTRL_DONE_BIT] && !field_q[FLD_CTRL][CTRL_ERR_BIT])); // R5
    AST_BASE_LO_RO_HELD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fld == FLD_BASE_LO)
        |=> (field_q[FLD_BASE_LO][27:0] == $past(field_q[FLD_BASE_LO][27:0]))); // R2
endmodule

// File: rtl/hdm_reg_bank.sv
module hdm_reg_bank
    import hdm_regs_pkg::*;
#(
    parameter int ADDR_W          = 8,
    parameter int NUM_DEC         = 4,
    parameter bit DEV_IS_ENDPOINT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);
    localparam int          DEC_W       = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1;
    localparam logic [31:0] TGT_LO_MASK = DEV_IS_ENDPOINT ? MASK_LOW : MASK_FULL;
    localparam logic [31:0] CAP_VALUE   = cap_word(NUM_DEC);

    tgt_e             kind;
    fld_e             fld;
    logic [DEC_W-1:0] idx;
    logic             wr_ok;
    logic             rd_ok;
    logic [31:0]      gctrl_q;
    logic [31:0]      slot_rd [NUM_DEC];
    logic [31:0]      rd_sel;

    hdm_addr_decode #(.ADDR_W(ADDR_W), .NUM_DEC(NUM_DEC), .DEC_W(DEC_W)) u_dec (
        .addr (req_addr),
        .kind (kind),
        .fld  (fld),
        .idx  (idx)
    );

    assign wr_ok = req_valid && req_write && !req_wide;
    assign rd_ok = req_valid && !req_write;

    for (genvar i = 0; i < NUM_DEC; i++) begin : g_slot
        hdm_dec_slot #(.TGT_LO_MASK(TGT_LO_MASK)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_ok && kind == TGT_DEC && idx == DEC_W'(i)),
            .fld     (fld),
            .wdata   (req_wdata),
            .rd_data (slot_rd[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)                             gctrl_q <= '0;
        else if (wr_ok && kind == TGT_GCTRL) gctrl_q <= (req_wdata & MASK_GCTRL) | (gctrl_q & ~MASK_GCTRL);
    end

    always_comb begin
        case (kind)
            TGT_CAP:   rd_sel = CAP_VALUE;
            TGT_GCTRL: rd_sel = gctrl_q;
            TGT_DEC:   rd_sel = slot_rd[idx];
            default:   rd_sel = 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_ok;
            if (rd_ok) rsp_rdata <= req_wide ? 32'h0 : rd_sel;
        end
    end

    AST_WIDE_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_wide) |=> $stable(gctrl_q)); // R1
    AST_WIDE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_wide) |=> (rsp_rdata == 32'h0)); // R1
    AST_GCTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (gctrl_q[31:2] == 30'h0)); // R6
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_ok |=> rsp_valid); // R10
    AST_NO_RSP_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> !rsp_valid); // R10
endmodule

// File: tb/hdm_reg_bank_tb.sv
module hdm_reg_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_wide;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int applied = 0;
    int bad     = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    hdm_reg_bank dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [7:0] a_of(input int d, input int f);
        return 8'(16 + d * 32 + f * 4);
    endfunction

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic wide = 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_wide = wide;
        req_addr = a; req_wdata = d;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag, input logic wide = 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_wide = wide;
        req_addr = a; req_wdata = 32'h0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares each response with the oldest expectation.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            applied++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R10 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string       t = tag_q.pop_front();
                if (rsp_rdata !== e) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", t, rsp_rdata, e);
                end
            end
        end
    end

    initial begin
        fork
            begin
                rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0;
                req_addr = '0; req_wdata = '0;
                repeat (3) @(negedge clk);
                rst = 1'b0;
                // reset state
                rd(8'h00, 32'h0000_0312, "R7 capability");
                rd(8'h04, 32'h0, "R6 gctrl reset");
                rd(a_of(0, 4), 32'h0, "R10 ctrl reset");
                // global control and capability
                wr(8'h04, 32'hFFFF_FFFF);
                rd(8'h04, 32'h3, "R6 gctrl mask");
                wr(8'h00, 32'h0);
                rd(8'h00, 32'h0000_0312, "R7 capability read-only");
                // masking
                wr(a_of(1, 0), 32'hFFFF_FFFF);
                rd(a_of(1, 0), 32'hF000_0000, "R2 base low");
                wr(a_of(1, 1), 32'h1234_5678);
                rd(a_of(1, 1), 32'h1234_5678, "R2 base high");
                wr(a_of(2, 2), 32'hABCD_EF12);
                rd(a_of(2, 2), 32'hA000_0000, "R2 size low");
                wr(a_of(2, 3), 32'h8765_4321);
                rd(a_of(2, 3), 32'h8765_4321, "R2 size high");
                rd(a_of(0, 1), 32'h0, "R2 neighbour slot untouched");
                // commit logic
                wr(a_of(0, 4), 32'hFFFF_FFFF);
                rd(a_of(0, 4), 32'h0000_17FF, "R3 R4 ctrl commit all-ones");
                wr(a_of(0, 4), 32'h0000_01FF);
                rd(a_of(0, 4), 32'h0000_01FF, "R5 ctrl uncommit");
                wr(a_of(3, 4), 32'h0000_0200);
                rd(a_of(3, 4), 32'h0000_0600, "R4 ctrl commit only");
                wr(a_of(3, 4), 32'h0000_0C00);
                rd(a_of(3, 4), 32'h0, "R5 status bits not writable");
                // target list
                wr(a_of(2, 5), 32'hFFFF_FFFF);
                rd(a_of(2, 5), 32'hF000_0000, "R8 target low endpoint mask");
                wr(a_of(2, 6), 32'h5A5A_A5A5);
                rd(a_of(2, 6), 32'h5A5A_A5A5, "R2 target high");
                // 64-bit access
                wr(8'h04, 32'h0, 1'b1);
                rd(8'h04, 32'h3, "R1 wide write ignored");
                rd(8'h00, 32'h0, "R1 wide read zero", 1'b1);
                // unmapped / unaligned
                wr(a_of(0, 7), 32'hFFFF_FFFF);
                rd(a_of(0, 7), 32'h0, "R9 unmapped slot word");
                rd(8'h08, 32'h0, "R9 unmapped low word");
                rd(8'hFC, 32'h0, "R9 beyond map");
                wr(a_of(1, 0) + 8'd1, 32'h0);
                rd(a_of(1, 0), 32'hF000_0000, "R9 unaligned write dropped");
                rd(8'h05, 32'h0, "R9 unaligned read");
                idle();
                idle();
                // reset mid-run
                @(negedge clk); rst = 1'b1;
                @(negedge clk); rst = 1'b0;
                rd(8'h04, 32'h0, "R10 gctrl after reset");
                rd(a_of(1, 1), 32'h0, "R10 base high after reset");
                idle();
                repeat (4) @(negedge clk);
                if (exp_q.size() != 0) begin
                    bad++;
                    $display("FAIL R10 missing responses actual=%0d expected=0", exp_q.size());
                end
            end
            begin
                repeat (5000) @(posedge clk);
                bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule